// File: doc/BRIEF.md
# Byte-Wide Flash Command Interpreter

This block is a synthesizable slave model of a small byte-wide flash array backed by an internal memory. A host drives an address with a read or write strobe. Write strobes are read as commands. There are four: a return to array read, an identification mode, a two-write row erase and a two-write byte program. Erase and program start an internal operation that lasts a set number of clock cycles. The length for each kind is a parameter.

While an internal operation runs, reads return a status byte in place of array data. Bit 6 of that byte alternates on each successive read. Bit 7 is the complement of bit 7 of the byte that launched the operation. A host can therefore wait for completion in either of two ways: read until bit 6 holds still, or read until bit 7 matches the value it wrote. A separate write-enable input, driven by an outside protection detector, gates whether erase and program may change the array.

Top module: `flash_cmd_slave`

## Requirements
- R1: After reset, no operation is running, the read data output is 0x00, the command state is array read, and every array byte reads 0xFF.
- R2: After a write of 0x90 (when not busy), a read of address 0 returns 0xBF, a read of address 1 returns 0x04, and any other address returns 0x00.
- R3: A write of 0xFF, when not busy and not in the program-data step, returns the block to array read mode.
- R4: A write of 0x20 followed by a write of 0xD0 sets to 0xFF all 256 bytes of the row selected by the address bits above bit 7 of the second write. Other rows keep their contents. If the second write is any value other than 0xD0, the erase is dropped and the block returns to array read.
- R5: A write of 0x10 followed by any data byte programs the byte at the address of the second write. The new value is the old value AND the data.
- R6: While busy, each read returns bit 6 = 0 on the first read after the operation starts, and bit 6 inverts on each read after that. Bits 5..0 read 0. Once the operation ends, reads return array data.
- R7: While busy, bit 7 of each read is the inverse of bit 7 of the write that started the operation. For an erase, that write is 0xD0.
- R8: While the write-enable input is low, the confirming write of an erase or a program does not start an operation and leaves the array unchanged.
- R9: Writes received while busy are ignored: they change neither the command state nor the array.
- R10: An erase keeps the block busy for exactly ERASE_CYC clock cycles, and a program keeps it busy for exactly PROG_CYC cycles. With a read every cycle starting right after the start, exactly that many reads return status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | $clog2(ROWS*ROW_BYTES) | Byte address for reads and writes |
| wdata | input | 8 | Command or data byte |
| rd_en | input | 1 | Read strobe; rdata updates on the next clock edge |
| wr_en | input | 1 | Write strobe |
| wp_ok | input | 1 | Write enable from the protection detector |
| rdata | output | 8 | Registered read data or status byte |

## Verification
Programming is tried twice on the same byte: first on an erased cell, then with a pattern that overlaps the first. The second result shows the AND merge, which a plain overwrite would not give. The status stream is read back to back on a program whose data has bit 7 clear, and again on an erase, whose confirming byte has bit 7 set. This tells a correct complement apart from a fixed polarity, and the count of status reads measures each busy length separately. Erasing one row while a neighbouring row holds programmed data separates row selection from a whole-array clear. Stray commands issued during a busy period, an erase aborted with a wrong confirm byte, and confirms sent with the write enable low each show through later reads whether the state or the array was disturbed.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_PROG    = 8'h10;
  localparam logic [7:0] MAKER_CODE = 8'hBF;
  localparam logic [7:0] PART_CODE  = 8'h04;

  typedef enum logic [1:0] {
    M_ARRAY     = 2'd0,
    M_IDENT     = 2'd1,
    M_ERASE_ARM = 2'd2,
    M_PROG_ARM  = 2'd3
  } mode_e;

  // cells may only move from 1 to 0 when programmed
  function automatic logic [7:0] prog_merge(input logic [7:0] old_v, input logic [7:0] d);
    return old_v & d;
  endfunction

  function automatic logic [7:0] busy_status(input logic last_b7, input logic tog);
    return {~last_b7, tog, 6'b000000};
  endfunction

  function automatic logic [7:0] ident_byte(input logic [31:0] a);
    if (a == 32'd0) return MAKER_CODE;
    if (a == 32'd1) return PART_CODE;
    return 8'h00;
  endfunction
endpackage

// File: rtl/fc_ctrl.sv
module fc_ctrl
  import fcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       wp_ok,
  input  logic [7:0] wdata,
  input  logic       busy,
  output mode_e      mode,
  output logic       erase_go,
  output logic       prog_go,
  output logic       last_b7,
  output logic       tog
);
  logic accept;

  always_comb begin
    accept   = wr_en && !busy;
    erase_go = accept && (mode == M_ERASE_ARM) && (wdata == OP_CONFIRM) && wp_ok;
    prog_go  = accept && (mode == M_PROG_ARM) && wp_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_ARRAY;
    end else if (accept) begin
      case (mode)
        M_PROG_ARM, M_ERASE_ARM: mode <= M_ARRAY;
        default: begin
          case (wdata)
            OP_ARRAY: mode <= M_ARRAY;
            OP_IDENT: mode <= M_IDENT;
            OP_ERASE: mode <= M_ERASE_ARM;
            OP_PROG:  mode <= M_PROG_ARM;
            default:  mode <= mode;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_b7 <= 1'b0;
      tog     <= 1'b0;
    end else if (erase_go || prog_go) begin
      last_b7 <= wdata[7];
      tog     <= 1'b0;
    end else if (rd_en && busy) begin
      tog <= ~tog;
    end
  end
endmodule

// File: rtl/fc_timer.sv
module fc_timer #(
  parameter int ERASE_CYC = 400,
  parameter int PROG_CYC  = 40,
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase_go,
  input  logic          prog_go,
  output logic          busy,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (erase_go)     cnt <= CW'(ERASE_CYC);
    else if (prog_go)      cnt <= CW'(PROG_CYC);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/fc_array.sv
module fc_array
  import fcmd_pkg::*;
#(
  parameter int ROWS      = 4,
  parameter int ROW_BYTES = 256,
  localparam int DEPTH = ROWS * ROW_BYTES,
  localparam int AW    = $clog2(DEPTH),
  localparam int OW    = $clog2(ROW_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase_go,
  input  logic          prog_go,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rd_byte
);
  logic [7:0] mem [DEPTH];
  logic [AW-OW-1:0] row_sel;

  assign row_sel = addr[AW-1:OW];
  assign rd_byte = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
    end else if (erase_go) begin
      for (int i = 0; i < ROW_BYTES; i++) mem[{row_sel, OW'(i)}] <= 8'hFF;
    end else if (prog_go) begin
      mem[addr] <= prog_merge(mem[addr], wdata);
    end
  end
endmodule

// File: rtl/flash_cmd_slave.sv
module flash_cmd_slave
  import fcmd_pkg::*;
#(
  parameter int ROWS      = 4,
  parameter int ROW_BYTES = 256,
  parameter int ERASE_CYC = 400,
  parameter int PROG_CYC  = 40
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [$clog2(ROWS*ROW_BYTES)-1:0]  addr,
  input  logic [7:0]                         wdata,
  input  logic                               rd_en,
  input  logic                               wr_en,
  input  logic                               wp_ok,
  output logic [7:0]                         rdata
);
  localparam int AW   = $clog2(ROWS * ROW_BYTES);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  mode_e         mode_w;
  logic          erase_go_w, prog_go_w, busy_w, tog_w, last_b7_w;
  logic [CW-1:0] cnt_w;
  logic [7:0]    arr_byte_w;

  fc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wp_ok(wp_ok),
    .wdata(wdata), .busy(busy_w), .mode(mode_w), .erase_go(erase_go_w),
    .prog_go(prog_go_w), .last_b7(last_b7_w), .tog(tog_w)
  );

  fc_timer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .erase_go(erase_go_w), .prog_go(prog_go_w),
    .busy(busy_w), .cnt(cnt_w)
  );

  fc_array #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n), .erase_go(erase_go_w), .prog_go(prog_go_w),
    .addr(addr), .wdata(wdata), .rd_byte(arr_byte_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= 8'h00;
    end else if (rd_en) begin
      if (busy_w)                 rdata <= busy_status(last_b7_w, tog_w);
      else if (mode_w == M_IDENT) rdata <= ident_byte(32'(addr));
      else                        rdata <= arr_byte_w;
    end
  end
endmodule

// File: rtl/fcmd_checker.sv
module fcmd_checker
  import fcmd_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          wr_en,
  input logic          wp_ok,
  input logic [AW-1:0] addr,
  input logic [7:0]    rdata,
  input logic          busy,
  input logic          erase_go,
  input logic          prog_go,
  input logic          tog,
  input logic          last_b7,
  input logic [CW-1:0] cnt,
  input mode_e         mode
);
  a_r2_ident_maker: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rd_en && mode == M_IDENT && addr == '0) |=> rdata == MAKER_CODE);

  a_r6_toggle_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> (rdata[6] == $past(tog)) && (rdata[5:0] == 6'd0));

  a_r7_inverted_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> rdata[7] == !$past(last_b7));

  a_r8_locked_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wp_ok && !busy) |=> !busy);

  a_r9_busy_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> mode == $past(mode));

  a_r10_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !erase_go && !prog_go) |=> cnt == $past(cnt) - 1'b1);

  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_go || prog_go) |=> busy);
endmodule

bind flash_cmd_slave fcmd_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .wp_ok(wp_ok),
  .addr(addr), .rdata(rdata), .busy(busy_w), .erase_go(erase_go_w),
  .prog_go(prog_go_w), .tog(tog_w), .last_b7(last_b7_w), .cnt(cnt_w),
  .mode(mode_w)
);

// File: tb/flash_cmd_slave_bench.sv
module flash_cmd_slave_bench;
  localparam int EC = 20;
  localparam int PC = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0, wp_ok = 1'b1;
  logic [7:0] rdata;

  int checks = 0, fails = 0;
  logic [7:0] seen;
  logic pend = 1'b0;

  typedef struct { logic [7:0] exp; bit chk; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  flash_cmd_slave #(.ROWS(4), .ROW_BYTES(256), .ERASE_CYC(EC), .PROG_CYC(PC)) u_flash_cmd_slave (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_en(rd_en),
    .wr_en(wr_en), .wp_ok(wp_ok), .rdata(rdata)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expectation of each read as its result appears
  always @(posedge clk) pend <= rd_en;
  always @(negedge clk) begin
    if (pend && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      seen = rdata;
      if (e.chk) check(rdata === e.exp, e.tag, int'(rdata), int'(e.exp));
    end
  end

  // driver tasks start and end at a falling edge
  task automatic rd(input logic [9:0] a, input logic [7:0] exp, input bit chk,
                    input string tag, output logic [7:0] v);
    q.push_back('{exp, chk, tag});
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    #1 v = seen;
  endtask

  task automatic rdc(input logic [9:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rd(a, exp, 1'b1, tag, v);
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // reads back to back until data appears; checks each status byte
  task automatic poll(input logic [9:0] a, input logic b7, input string tag, output int n);
    logic [7:0] v;
    n = 0;
    for (int k = 0; k < 200; k++) begin
      rd(a, 8'h00, 1'b0, "", v);
      if (v[5:0] != 6'd0) break;
      check(v == {~b7, n[0], 6'b0}, tag, int'(v), int'({~b7, n[0], 6'b0}));
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(rdata == 8'h00, "R1 reset rdata", int'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    rdc(10'h005, 8'hFF, "R1 array erased at reset");

    // R5/R6/R7/R10: program 0x3C into an erased byte, bit7 of data is 0
    wr(10'h005, 8'h10); wr(10'h005, 8'h3C);
    poll(10'h005, 1'b0, "R6 R7 program status", n);
    check(n == PC, "R10 program busy reads", n, PC);
    rdc(10'h005, 8'h3C, "R5 programmed byte");
    wr(10'h005, 8'h10); wr(10'h005, 8'hF0);
    poll(10'h005, 1'b1, "R7 status msb set", n);
    rdc(10'h005, 8'h30, "R5 AND merge");

    // R2/R3: identification, then back to array
    wr(10'h000, 8'h90);
    rdc(10'h000, 8'hBF, "R2 maker code");
    rdc(10'h001, 8'h04, "R2 part code");
    rdc(10'h002, 8'h00, "R2 other address");
    wr(10'h000, 8'hFF);
    rdc(10'h005, 8'h30, "R3 back to array");

    // R8: locked writes do nothing
    wp_ok = 1'b0;
    wr(10'h007, 8'h10); wr(10'h007, 8'h00);
    rdc(10'h007, 8'hFF, "R8 locked program");
    wr(10'h010, 8'h20); wr(10'h010, 8'hD0);
    rdc(10'h005, 8'h30, "R8 locked erase");
    wp_ok = 1'b1;

    // R4/R10: erase row 0 while row 1 holds data
    wr(10'h105, 8'h10); wr(10'h105, 8'h11);
    poll(10'h105, 1'b0, "R6 row1 program", n);
    wr(10'h010, 8'h20); wr(10'h010, 8'hD0);
    poll(10'h010, 1'b1, "R7 erase status", n);
    check(n == EC, "R10 erase busy reads", n, EC);
    rdc(10'h005, 8'hFF, "R4 row erased");
    rdc(10'h0FF, 8'hFF, "R4 row end erased");
    rdc(10'h105, 8'h11, "R4 other row kept");

    // R9: commands during busy are dropped
    wr(10'h106, 8'h10); wr(10'h106, 8'h77);
    wr(10'h000, 8'h90); wr(10'h105, 8'h10); wr(10'h105, 8'h00);
    poll(10'h106, 1'b0, "R9 status after busy writes", n);
    rdc(10'h000, 8'hFF, "R9 ident ignored while busy");
    rdc(10'h105, 8'h11, "R9 program ignored while busy");
    rdc(10'h106, 8'h77, "R5 second row program");

    // R4 abort: wrong confirm byte
    wr(10'h105, 8'h20); wr(10'h105, 8'h55);
    rdc(10'h105, 8'h11, "R4 erase aborted");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule